// File: doc/BRIEF.md
# Phase-Shifted Multicell PWM Modulator

This block produces the gate commands for a chain of cascaded H-bridge cells that together form one output phase of a multilevel converter. Every cell owns a digital triangular carrier that repeats every `PERIOD` clock cycles. The carrier of each cell is delayed from its neighbour by `PERIOD/N_CELLS` cycles, so that the carriers are spread evenly over one period. With `N_CELLS` cells the phase can reach `2*N_CELLS+1` voltage levels, and the effective switching rate is `N_CELLS` times that of a single cell.

A signed reference `ref_in` is first limited to plus or minus full scale. Each cell takes a copy of the limited value at the start of its own carrier period. Because those instants are staggered by `PERIOD/N_CELLS` cycles, neighbouring cells can hold slightly different references. Each cell drives two legs with unipolar modulation: one leg compares the carrier with the held reference, and the other compares it with the negated reference. The two switches of a leg are always driven in complement.

A bypass input per cell overrides that cell's bridge. It turns on the shorting switch across the cell terminals and drives both legs to their low switch, which puts 0 V on the cell. The reference is a level that the block samples; it has no handshake. Bypass is a plain control input. Dead time and analogue gate drive belong to other blocks.

Top module: `psc_pwm_mod`

## Requirements
- R1: While reset is active and after it is released, cell i (counting from 0) has carrier count `i*PERIOD/N_CELLS` and a held reference of 0. With a held reference of 0, a cell's positive-leg and negative-leg high commands are equal, which gives a zero cell level. The shorting switch is off unless bypass is set.
- R2: Each carrier count runs 0 to `PERIOD-1` and then wraps to 0, one step per clock. The count of cell i+1 always equals the count of cell i plus `PERIOD/N_CELLS`, modulo `PERIOD`.
- R3: The triangle value is `tri = HALF-cnt` for `cnt < HALF` and `cnt-HALF` otherwise, where `HALF = PERIOD/2`. For a held reference h, the positive-leg high command is `2*tri < HALF+h` and the negative-leg high command is `2*tri < HALF-h`. Both are signed compares.
- R4: In every leg the low command is the inverse of the high command, so the two switches of a leg are never on together.
- R5: A cell loads the limited reference on the clock edge where its count wraps from `PERIOD-1` to 0, and holds that value for the whole of the next period.
- R6: `ref_in` is a two's-complement value in `REF_W` bits. Values above `HALF` are limited to `HALF`, and values below `-HALF` are limited to `-HALF`, before any cell loads them.
- R7: While `bypass[i]` is 1, cell i drives shorting switch on, both high commands 0 and both low commands 1, in the same cycle. Its carrier and its reference loading continue unchanged, so releasing bypass resumes modulation with the current held reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | REF_W | Signed voltage reference in carrier units |
| bypass | input | N_CELLS | Per-cell bypass request, bit i for cell i |
| p_hi | output | N_CELLS | Positive-leg high switch command per cell |
| p_lo | output | N_CELLS | Positive-leg low switch command per cell |
| n_hi | output | N_CELLS | Negative-leg high switch command per cell |
| n_lo | output | N_CELLS | Negative-leg low switch command per cell |
| short_on | output | N_CELLS | Cell shorting switch command per cell |

## Verification
Two functions can fall in the same cycle: a cell's bypass forcing and that cell's reference loading at its carrier wrap. The bench holds one cell in bypass across its wrap edge while `ref_in` changes. During bypass it checks that the forced zero state appears at the ports. After the bypass is released, it checks that the leg commands follow the reference loaded during the bypass and not the reference held before it. A bench model derives every cell's count and held reference from the reset preloads, and the bench compares every output against that model on every checked cycle.

// File: rtl/pspwm_pkg.sv
package pspwm_pkg;

  typedef struct packed {
    logic p_hi;
    logic p_lo;
    logic n_hi;
    logic n_lo;
    logic shorted;
  } cell_drive_t;

  function automatic int unsigned carrier_preload(int unsigned idx,
                                                  int unsigned period,
                                                  int unsigned cells);
    return (idx * period) / cells;
  endfunction

endpackage

// File: rtl/pspwm_carrier.sv
module pspwm_carrier #(
  parameter int unsigned PERIOD  = 40,
  parameter int unsigned PRELOAD = 0,
  parameter int unsigned CNT_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] tri_o,
  output logic             wrap_o
);
  localparam int unsigned HALF = PERIOD / 2;
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(PERIOD - 1);
  localparam logic [CNT_W-1:0] HALFV = CNT_W'(HALF);
  localparam logic [CNT_W-1:0] START = CNT_W'(PRELOAD);

  logic [CNT_W-1:0] cnt_q;

  assign wrap_o = (cnt_q == LAST);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= START;
    else if (wrap_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    if (cnt_q < HALFV) tri_o = HALFV - cnt_q;
    else               tri_o = cnt_q - HALFV;
  end

  // R2
  carrier_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == LAST) |=> (cnt_q == '0));

  // R2
  carrier_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != LAST) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

endmodule

// File: rtl/pspwm_ref_hold.sv
module pspwm_ref_hold #(
  parameter int unsigned REF_W = 8,
  parameter int unsigned HALF  = 20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic signed [REF_W-1:0] ref_lim,
  output logic signed [REF_W-1:0] held_o
);
  localparam logic signed [REF_W-1:0] POS_FS = REF_W'(HALF);
  localparam logic signed [REF_W-1:0] NEG_FS = -POS_FS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    held_o <= '0;
    else if (load) held_o <= ref_lim;
  end

  // R5
  held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(held_o));

  // R6
  held_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (held_o <= POS_FS) && (held_o >= NEG_FS));

endmodule

// File: rtl/pspwm_cell.sv
module pspwm_cell
  import pspwm_pkg::*;
#(
  parameter int unsigned PERIOD  = 40,
  parameter int unsigned PRELOAD = 0,
  parameter int unsigned REF_W   = 8,
  parameter int unsigned CNT_W   = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [REF_W-1:0] ref_lim,
  input  logic                    bypass,
  output cell_drive_t             drv_o,
  output logic [CNT_W-1:0]        cnt_o
);
  localparam int unsigned HALF = PERIOD / 2;
  localparam int unsigned CW   = REF_W + CNT_W + 2;
  localparam logic signed [CW-1:0] HALF_S = CW'(HALF);

  logic [CNT_W-1:0]        tri_v;
  logic                    wrap;
  logic signed [REF_W-1:0] held;
  logic signed [CW-1:0]    tri2_s, held_s, thr_p, thr_n;
  logic                    p_on, n_on;

  pspwm_carrier #(.PERIOD(PERIOD), .PRELOAD(PRELOAD), .CNT_W(CNT_W)) u_car (
    .clk(clk), .rst_n(rst_n), .cnt_o(cnt_o), .tri_o(tri_v), .wrap_o(wrap)
  );

  pspwm_ref_hold #(.REF_W(REF_W), .HALF(HALF)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(wrap), .ref_lim(ref_lim), .held_o(held)
  );

  always_comb begin
    tri2_s = $signed({{(CW-CNT_W-1){1'b0}}, tri_v, 1'b0});
    held_s = $signed({{(CW-REF_W){held[REF_W-1]}}, held});
    thr_p  = HALF_S + held_s;
    thr_n  = HALF_S - held_s;
    p_on   = (tri2_s < thr_p);
    n_on   = (tri2_s < thr_n);
  end

  always_comb begin
    if (bypass) begin
      drv_o.p_hi    = 1'b0;
      drv_o.n_hi    = 1'b0;
      drv_o.shorted = 1'b1;
    end else begin
      drv_o.p_hi    = p_on;
      drv_o.n_hi    = n_on;
      drv_o.shorted = 1'b0;
    end
    drv_o.p_lo = ~drv_o.p_hi;
    drv_o.n_lo = ~drv_o.n_hi;
  end

  // R4
  no_shoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(drv_o.p_hi && drv_o.p_lo) && !(drv_o.n_hi && drv_o.n_lo));

  // R7
  bypass_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |-> (drv_o.shorted && drv_o.p_lo && drv_o.n_lo && !drv_o.p_hi && !drv_o.n_hi));

  // R7
  short_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bypass |-> !drv_o.shorted);

endmodule

// File: rtl/psc_pwm_mod.sv
module psc_pwm_mod
  import pspwm_pkg::*;
#(
  parameter int unsigned N_CELLS = 5,
  parameter int unsigned PERIOD  = 40,
  parameter int unsigned REF_W   = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [REF_W-1:0] ref_in,
  input  logic [N_CELLS-1:0]      bypass,
  output logic [N_CELLS-1:0]      p_hi,
  output logic [N_CELLS-1:0]      p_lo,
  output logic [N_CELLS-1:0]      n_hi,
  output logic [N_CELLS-1:0]      n_lo,
  output logic [N_CELLS-1:0]      short_on
);
  localparam int unsigned HALF  = PERIOD / 2;
  localparam int unsigned STEP  = PERIOD / N_CELLS;
  localparam int unsigned CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic signed [REF_W-1:0] POS_FS = REF_W'(HALF);
  localparam logic signed [REF_W-1:0] NEG_FS = -POS_FS;

  logic signed [REF_W-1:0] ref_lim;
  logic [CNT_W-1:0]        cnt_v [N_CELLS];

  always_comb begin
    if (ref_in > POS_FS)      ref_lim = POS_FS;
    else if (ref_in < NEG_FS) ref_lim = NEG_FS;
    else                      ref_lim = ref_in;
  end

  for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
    cell_drive_t drv;

    pspwm_cell #(
      .PERIOD (PERIOD),
      .PRELOAD(carrier_preload(i, PERIOD, N_CELLS)),
      .REF_W  (REF_W),
      .CNT_W  (CNT_W)
    ) u_cell (
      .clk(clk), .rst_n(rst_n), .ref_lim(ref_lim), .bypass(bypass[i]),
      .drv_o(drv), .cnt_o(cnt_v[i])
    );

    assign p_hi[i]     = drv.p_hi;
    assign p_lo[i]     = drv.p_lo;
    assign n_hi[i]     = drv.n_hi;
    assign n_lo[i]     = drv.n_lo;
    assign short_on[i] = drv.shorted;

    if (i > 0) begin : g_phase
      // R2
      phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_v[i]) == ((int'(cnt_v[i-1]) + STEP) % PERIOD));
    end
  end

  // R6
  ref_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_lim <= POS_FS) && (ref_lim >= NEG_FS));

endmodule

// File: tb/psc_pwm_mod_test.sv
module psc_pwm_mod_test;
  localparam int N = 5;
  localparam int P = 40;
  localparam int H = P / 2;
  localparam int STEP = P / N;
  localparam int RW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic signed [RW-1:0] ref_in = '0;
  logic [N-1:0] bypass = '0;
  logic [N-1:0] p_hi, p_lo, n_hi, n_lo, short_on;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int m_cnt [N];
  int m_hold [N];

  always #10 clk = ~clk;

  psc_pwm_mod #(.N_CELLS(N), .PERIOD(P), .REF_W(RW)) uut (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .bypass(bypass),
    .p_hi(p_hi), .p_lo(p_lo), .n_hi(n_hi), .n_lo(n_lo), .short_on(short_on)
  );

  function automatic int lim(int v);
    if (v > H) return H;
    if (v < -H) return -H;
    return v;
  endfunction

  // model from R1, R2, R5, R6
  always @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (!rst_n) begin
        m_cnt[i]  <= i * STEP;
        m_hold[i] <= 0;
      end else if (m_cnt[i] == P - 1) begin
        m_cnt[i]  <= 0;
        m_hold[i] <= lim(int'(ref_in));
      end else begin
        m_cnt[i] <= m_cnt[i] + 1;
      end
    end
  end

  task automatic tick();
    @(negedge clk);
    #5;
  endtask

  task automatic check_all(string tag);
    for (int i = 0; i < N; i++) begin
      int tr, ea, eb;
      logic [4:0] got, exp;
      tr = (m_cnt[i] < H) ? H - m_cnt[i] : m_cnt[i] - H;
      ea = (2 * tr < H + m_hold[i]) ? 1 : 0;
      eb = (2 * tr < H - m_hold[i]) ? 1 : 0;
      if (bypass[i]) begin ea = 0; eb = 0; end
      exp = {1'(ea), ~1'(ea), 1'(eb), ~1'(eb), bypass[i]};
      got = {p_hi[i], p_lo[i], n_hi[i], n_lo[i], short_on[i]};
      checks++;
      if (got !== exp) begin
        failures++;
        $display("FAIL %s cell %0d: got %b expected %b", tag, i, got, exp);
      end
    end
  endtask

  task automatic t_reset();
    #5;
    checks++;
    if (short_on !== '0 || p_hi !== n_hi || p_lo !== ~p_hi) begin
      failures++;
      $display("FAIL R1 in reset: short=%b p_hi=%b n_hi=%b expected short=0 p_hi==n_hi",
               short_on, p_hi, n_hi);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #5;
    check_all("R1 after release");
  endtask

  task automatic t_zero_phase();
    int r0, r1;
    logic prev0, prev1;
    r0 = -1; r1 = -1;
    ref_in = 0;
    prev0 = p_hi[0]; prev1 = p_hi[1];
    for (int c = 0; c < P + 2; c++) begin
      tick();
      check_all("R1 zero ref");
      checks++;
      if (p_hi !== n_hi) begin
        failures++;
        $display("FAIL R1 zero level: p_hi=%b n_hi=%b expected equal", p_hi, n_hi);
      end
      if (p_hi[0] && !prev0 && r0 < 0) r0 = c;
      if (p_hi[1] && !prev1 && r1 < 0) r1 = c;
      prev0 = p_hi[0]; prev1 = p_hi[1];
    end
    checks++;
    if (r0 < 0 || r1 < 0 || ((r0 - r1 + P) % P) != STEP) begin
      failures++;
      $display("FAIL R2 phase offset: got %0d expected %0d", (r0 - r1 + P) % P, STEP);
    end
  endtask

  task automatic t_level(int v, string tag);
    @(negedge clk);
    ref_in = RW'(v);
    for (int c = 0; c < 2 * P; c++) begin
      tick();
      check_all(tag);
    end
  endtask

  task automatic t_stagger();
    @(negedge clk);
    ref_in = RW'(12);
    for (int c = 0; c < STEP; c++) begin
      tick();
      check_all("R5 stagger");
    end
    @(negedge clk);
    ref_in = RW'(-6);
    for (int c = 0; c < P; c++) begin
      tick();
      check_all("R5 stagger");
    end
  endtask

  task automatic t_clamp();
    int hi_cnt;
    @(negedge clk);
    ref_in = RW'(100);
    repeat (P + 1) begin tick(); check_all("R6 clamp high"); end
    hi_cnt = 0;
    for (int c = 0; c < P; c++) begin
      tick();
      check_all("R6 clamp high");
      if (p_hi[3]) hi_cnt++;
    end
    checks++;
    if (hi_cnt != P - 1) begin
      failures++;
      $display("FAIL R6 full scale on-count: got %0d expected %0d", hi_cnt, P - 1);
    end
    @(negedge clk);
    ref_in = RW'(-128);
    repeat (2 * P) begin tick(); check_all("R6 clamp low"); end
  endtask

  task automatic t_bypass();
    @(negedge clk);
    ref_in = RW'(4);
    repeat (P) begin tick(); check_all("R7 pre"); end
    @(negedge clk);
    bypass = 5'b00100;
    ref_in = RW'(-14);
    for (int c = 0; c < P + 3; c++) begin
      tick();
      check_all("R7 bypass");
      checks++;
      if (short_on !== 5'b00100 || p_hi[2] || n_hi[2]) begin
        failures++;
        $display("FAIL R7 forced state: short=%b p_hi=%b n_hi=%b expected short=00100 hi=0",
                 short_on, p_hi, n_hi);
      end
    end
    @(negedge clk);
    bypass = '0;
    repeat (P) begin tick(); check_all("R7 release"); end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired: got running expected finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_zero_phase();
    t_level(10, "R3 positive");
    t_level(-15, "R3 negative");
    t_stagger();
    t_clamp();
    t_bypass();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule